// File: doc/BRIEF.md
# Burst Address Sequencer with Dual Strobes

This block holds the word address of a synchronous burst memory and presents the array address for the current cycle. An access begins when either of two active-low address strobes is sampled low on a rising clock edge. One strobe comes from the processor and the other from a cache controller. The external address is then captured and the internal beat counter returns to zero. After that, each sampled advance pulse moves the low two address bits to the next beat of a four-word group. The upper bits stay where they were loaded.

The beat order is set by a static strap pin. When the pin is low, the low bits count upward modulo four from the start value. When the pin is high, the low bits equal the start value XOR the beat count. The strap is sampled once, in the first clock after reset, and is then held.

The processor strobe only takes effect while the primary chip enable is low. The controller strobe is always honoured. When the controller strobe is seen with the chip enable high, the access becomes a deselect. The block reports whether a burst is active and which strobe started the current access.

Top module: `burst_seq`

## Requirements
- R1: While synchronous reset is high, the next edge drives the address output to 0, the burst-active flag to 0 and the source flag to 0.
- R2: The controller strobe low with the chip enable low (processor strobe high) loads the input address, which appears on the output after that edge. It sets burst-active to 1 and the source flag to 1.
- R3: The processor strobe low with the chip enable low loads the input address and sets burst-active to 1 and the source flag to 0.
- R4: The processor strobe low with the chip enable high (controller strobe high) is ignored. The address output, burst-active and source flag keep their values.
- R5: The controller strobe low with the chip enable high is a deselect. The input address is loaded with the beat count cleared, and burst-active becomes 0.
- R6: When both strobes are low with the chip enable low, the processor strobe takes precedence and the source flag becomes 0.
- R7: With the strap sampled low, each advance (advance low, no strobe, burst active) sets the low two output bits to the previous value plus 1 modulo 4. From a start value of 1 the sequence is 2, 3, 0, 1.
- R8: With the strap sampled high, the low two output bits equal the start value XOR the beat count. From a start value of 1 the sequence is 0, 3, 2, 1.
- R9: Advancing never changes address bits 16 down to 2.
- R10: A strobe during a burst abandons it. The new address appears with the beat count at zero, even if advance is also low.
- R11: With both strobes high and advance high, the address output holds.
- R12: The strap is sampled in the first cycle after reset. Later changes to it do not alter the beat order until the next reset.
- R13: Advance has no effect while burst-active is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Active-high synchronous reset |
| addr_in | input | 17 | External start address |
| strobe_cpu_n | input | 1 | Processor address strobe, active low |
| strobe_ctl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| order_sel | input | 1 | Static beat-order strap: 0 linear, 1 interleaved |
| chip_en_n | input | 1 | Primary chip enable, active low |
| addr_out | output | 17 | Current array address |
| burst_active | output | 1 | High while a selected access is in progress |
| started_by_ctl | output | 1 | 1 if the controller strobe started the access, 0 if the processor strobe did |

## Verification
The bench uses a start value of 1. For that start, linear and interleaved orders give different second beats, whereas a start of 2 would yield the same sequence under both orders and could not tell them apart.

Four further cases target specific faults:
- A processor strobe issued with the chip enable high is checked for leaving the address and flags untouched. A design that gates the strobe wrongly would reload the address or deselect.
- A strobe issued together with advance is checked for restarting at beat zero. A design that lets advance win would show the start address plus one.
- Advancing after a deselect is checked for having no effect on the address.
- Changing the strap in the middle of a run is checked for having no effect. A design that reads the pin live would switch order on the next burst.

// File: rtl/burst_seq.sv
module burst_seq #(
  parameter int ADDR_W  = 17,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              strobe_cpu_n,
  input  logic              strobe_ctl_n,
  input  logic              adv_n,
  input  logic              order_sel,
  input  logic              chip_en_n,
  output logic [ADDR_W-1:0] addr_out,
  output logic              burst_active,
  output logic              started_by_ctl
);

  logic [ADDR_W-1:0]  base;
  logic [BURST_W-1:0] cnt;
  logic [BURST_W-1:0] low;
  logic               order_q, order_vld;
  logic               cpu_go, load;

  assign cpu_go = !strobe_cpu_n && !chip_en_n;
  assign load   = cpu_go || !strobe_ctl_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      base           <= '0;
      cnt            <= '0;
      burst_active   <= 1'b0;
      started_by_ctl <= 1'b0;
      order_q        <= 1'b0;
      order_vld      <= 1'b0;
    end else begin
      if (!order_vld) begin
        order_q   <= order_sel;
        order_vld <= 1'b1;
      end
      if (load) begin
        base           <= addr_in;
        cnt            <= '0;
        burst_active   <= !chip_en_n;
        started_by_ctl <= !cpu_go;
      end else if (!adv_n && burst_active) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign low      = order_q ? (base[BURST_W-1:0] ^ cnt) : (base[BURST_W-1:0] + cnt);
  assign addr_out = {base[ADDR_W-1:BURST_W], low};

endmodule

// File: rtl/burst_seq_chk.sv
module burst_seq_chk #(
  parameter int ADDR_W  = 17,
  parameter int BURST_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr_in,
  input logic              strobe_cpu_n,
  input logic              strobe_ctl_n,
  input logic              adv_n,
  input logic              chip_en_n,
  input logic [ADDR_W-1:0] addr_out,
  input logic              burst_active,
  input logic              started_by_ctl,
  input logic              order_q
);

  logic idle;
  assign idle = strobe_cpu_n && strobe_ctl_n;

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (addr_out == '0) && !burst_active && !started_by_ctl);

  p_ctl_load_r2: assert property (@(posedge clk) disable iff (rst)
    (!strobe_ctl_n && !chip_en_n && strobe_cpu_n) |=>
      (addr_out == $past(addr_in)) && burst_active && started_by_ctl);

  p_cpu_load_r3: assert property (@(posedge clk) disable iff (rst)
    (!strobe_cpu_n && !chip_en_n) |=>
      (addr_out == $past(addr_in)) && burst_active && !started_by_ctl);

  p_cpu_block_r4: assert property (@(posedge clk) disable iff (rst)
    (!strobe_cpu_n && chip_en_n && strobe_ctl_n && adv_n) |=>
      $stable(addr_out) && $stable(burst_active) && $stable(started_by_ctl));

  p_deselect_r5: assert property (@(posedge clk) disable iff (rst)
    (!strobe_ctl_n && chip_en_n) |=> !burst_active && (addr_out == $past(addr_in)));

  p_linear_r7: assert property (@(posedge clk) disable iff (rst)
    (idle && !adv_n && burst_active && !order_q) |=>
      (addr_out[BURST_W-1:0] == BURST_W'($past(addr_out[BURST_W-1:0]) + 1'b1)));

  p_upper_r9: assert property (@(posedge clk) disable iff (rst)
    idle |=> $stable(addr_out[ADDR_W-1:BURST_W]));

  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (idle && adv_n) |=> $stable(addr_out) && $stable(burst_active));

  p_idle_adv_r13: assert property (@(posedge clk) disable iff (rst)
    (idle && !burst_active) |=> $stable(addr_out));

endmodule

bind burst_seq burst_seq_chk #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_chk (
  .clk(clk), .rst(rst), .addr_in(addr_in), .strobe_cpu_n(strobe_cpu_n),
  .strobe_ctl_n(strobe_ctl_n), .adv_n(adv_n), .chip_en_n(chip_en_n),
  .addr_out(addr_out), .burst_active(burst_active),
  .started_by_ctl(started_by_ctl), .order_q(order_q)
);

// File: tb/burst_seq_tb.sv
module burst_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [16:0] addr_in = '0;
  logic        strobe_cpu_n = 1'b1, strobe_ctl_n = 1'b1, adv_n = 1'b1;
  logic        order_sel = 1'b0, chip_en_n = 1'b0;
  logic [16:0] addr_out;
  logic        burst_active, started_by_ctl;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_seq u_dut (
    .clk(clk), .rst(rst), .addr_in(addr_in), .strobe_cpu_n(strobe_cpu_n),
    .strobe_ctl_n(strobe_ctl_n), .adv_n(adv_n), .order_sel(order_sel),
    .chip_en_n(chip_en_n), .addr_out(addr_out), .burst_active(burst_active),
    .started_by_ctl(started_by_ctl)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(logic cpu_n, logic ctl_n, logic av_n, logic ce_n, logic [16:0] a);
    @(negedge clk);
    strobe_cpu_n = cpu_n; strobe_ctl_n = ctl_n; adv_n = av_n; chip_en_n = ce_n; addr_in = a;
    @(posedge clk);
    #1;
  endtask

  function automatic logic [16:0] with_low(logic [16:0] a, logic [1:0] l);
    return {a[16:2], l};
  endfunction

  task automatic t_reset(logic ord);
    @(negedge clk);
    rst = 1'b1; order_sel = ord;
    strobe_cpu_n = 1'b1; strobe_ctl_n = 1'b1; adv_n = 1'b1; chip_en_n = 1'b0;
    @(posedge clk); @(posedge clk); #1;
    check("R1 addr", addr_out, 0);
    check("R1 active", burst_active, 0);
    check("R1 source", started_by_ctl, 0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_ctl_linear();
    logic [16:0] a = 17'h0A5C5;
    logic [1:0] seq [4] = '{2'd2, 2'd3, 2'd0, 2'd1};
    cyc(1, 0, 1, 0, a);
    check("R2 addr", addr_out, a);
    check("R2 active", burst_active, 1);
    check("R2 source", started_by_ctl, 1);
    for (int i = 0; i < 4; i++) begin
      cyc(1, 1, 0, 0, 17'h1FFFF);
      check("R7 linear beat", addr_out, with_low(a, seq[i]));
      check("R9 upper bits", addr_out[16:2], a[16:2]);
    end
    cyc(1, 1, 1, 0, 17'h12345);
    check("R11 hold", addr_out, a);
  endtask

  task automatic t_cpu_gate();
    logic [16:0] b = 17'h13332;
    logic [16:0] prev = addr_out;
    cyc(0, 1, 1, 1, 17'h0F0F0);
    check("R4 addr kept", addr_out, prev);
    check("R4 active kept", burst_active, 1);
    check("R4 source kept", started_by_ctl, 1);
    cyc(0, 1, 1, 0, b);
    check("R3 addr", addr_out, b);
    check("R3 active", burst_active, 1);
    check("R3 source", started_by_ctl, 0);
  endtask

  task automatic t_both_and_restart();
    logic [16:0] c = 17'h0C0C1;
    logic [16:0] d = 17'h15551;
    cyc(1, 0, 1, 0, 17'h00000);
    cyc(0, 0, 1, 0, c);
    check("R6 addr", addr_out, c);
    check("R6 source", started_by_ctl, 0);
    cyc(1, 1, 0, 0, 17'h0);
    cyc(1, 1, 0, 0, 17'h0);
    check("R7 mid burst", addr_out, with_low(c, 2'd3));
    cyc(1, 0, 0, 0, d);
    check("R10 restart at zero", addr_out, d);
    cyc(1, 1, 0, 0, 17'h0);
    check("R10 first beat after restart", addr_out, with_low(d, 2'd2));
  endtask

  task automatic t_deselect();
    logic [16:0] e = 17'h1E002;
    cyc(1, 0, 1, 1, e);
    check("R5 inactive", burst_active, 0);
    check("R5 addr loaded", addr_out, e);
    cyc(1, 1, 0, 0, 17'h0);
    check("R13 advance ignored", addr_out, e);
    check("R13 still inactive", burst_active, 0);
  endtask

  task automatic t_interleaved();
    logic [16:0] f = 17'h07771;
    logic [16:0] g = 17'h1BEE1;
    logic [1:0] seq [4] = '{2'd0, 2'd3, 2'd2, 2'd1};
    t_reset(1'b1);
    cyc(1, 0, 1, 0, f);
    check("R2 addr interleaved run", addr_out, f);
    for (int i = 0; i < 4; i++) begin
      cyc(1, 1, 0, 0, 17'h0);
      check("R8 interleaved beat", addr_out, with_low(f, seq[i]));
      check("R9 upper bits", addr_out[16:2], f[16:2]);
    end
    @(negedge clk); order_sel = 1'b0;
    cyc(0, 1, 1, 0, g);
    cyc(1, 1, 0, 0, 17'h0);
    check("R12 strap change ignored", addr_out, with_low(g, 2'd0));
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    t_reset(1'b0);
    t_ctl_linear();
    t_cpu_gate();
    t_both_and_restart();
    t_deselect();
    t_interleaved();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule